// File: doc/BRIEF.md
# I2C Transaction Offload Sequencer

This block runs a complete short I2C master transaction on its own, starting from a single write to its control register. It sits above a byte-level bus engine and issues that engine one command at a time: START, repeated START, STOP, write a byte, or read a byte with ACK or NACK. It waits for each command to complete before it issues the next.

The block supports three kinds of transaction. The first writes 1 to 8 bytes. The second reads 1 to 8 bytes. The third writes and then reads, with either a repeated start or a STOP/START pair between the two phases. Outgoing bytes come from two 32-bit transmit registers, and received bytes land in two 32-bit receive registers. At the end, a cause flag and an error flag report the outcome, and the cause flag drives an interrupt line. The host only has to load the data, write one control word, wait for the interrupt and read the results.

Top module: `i2c_txn_offload`

## Requirements
- R1: Control word fields are as follows:
  - bit 0: write phase.
  - bit 1: read phase.
  - bits [11:2]: slave address.
  - bit 12: 10-bit addressing.
  - bits [15:13]: write length minus one.
  - bits [18:16]: read length minus one.
  - bit 19: enable/launch.
  - bit 20: repeated start between the phases.
  
  A transaction launches only from idle, and only when bit 19 and at least one phase bit are set. Reading the control word returns the stored word, with bit 19 replaced by a busy indication.
- R2: Register word indices are as follows:
  - 0: control.
  - 1: TX low.
  - 2: TX high.
  - 3: RX low.
  - 4: RX high.
  - 5: status, with bit 0 as the error flag.
  - 6: cause, with bit 0 as the done flag.
  
  The `irq` output mirrors the cause flag. After reset, all of these read zero.
- R3: Bytes are packed little-endian across the register pair. Byte 0 is in bits [7:0] of the low word, and byte 4 is in bits [7:0] of the high word.
- R4: A write transaction issues START, then the address byte {addr[6:0],0}, then the N data bytes in order, then STOP. When it finishes, cause is 1 and error is 0.
- R5: A read transaction issues START, then {addr[6:0],1}, then N-1 READ_ACK commands, then one READ_NACK, then STOP. Received bytes are stored by index. Receive bytes that were never received read as zero, because a launch clears the RX registers.
- R6: With both phases and bit 20 set, the write phase is followed by RESTART, then the read-direction address, then the read phase.
- R7: With both phases and bit 20 clear, the two phases are separated by STOP and then a fresh START.
- R8: With 10-bit addressing, every phase sends two address bytes: first {5'b11110, addr[9:8], dir}, then addr[7:0].
- R9: If the slave NACKs an address byte or a data byte, the next command is STOP and the remaining phases are skipped. The transaction then ends with error=1 and cause=1.
- R10: If the engine reports a fault on any command other than STOP, the next command is STOP and the transaction ends with error=1 and cause=1. A read byte that faulted is not stored.
- R11: While busy, writes to the control register and to the TX registers are ignored, with one exception: a control write with bit 19 clear. That write lets the current command finish, then issues STOP, and the transaction ends with error=1 and cause=1.
- R12: Any write to the cause register clears it and drops `irq`. A launch clears cause and error.
- R13: Engine command codes are START=0, RESTART=1, STOP=2, WRITE=3, READ_ACK=4 and READ_NACK=5. `eng_req` stays high, and the command and byte stay stable, until `eng_done`. `eng_req` is low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, mirrors cause |
| eng_req | output | 1 | Command request to byte engine |
| eng_cmd | output | 3 | Command code |
| eng_byte | output | 8 | Byte to transmit for WRITE |
| eng_done | input | 1 | One-cycle command completion pulse |
| eng_nack | input | 1 | Slave NACK on a WRITE, valid with done |
| eng_fault | input | 1 | Bus fault, valid with done |
| eng_rx | input | 8 | Received byte, valid with done |

## Verification
The bench builds the block with its default `TEN_BIT_EN=1`. This makes the two-byte address path reachable alongside 7-bit addressing, so the table includes 10-bit write and 10-bit combined transactions next to the plain ones. A behavioural byte engine logs every command and can inject a NACK or a fault at a chosen command position. This reaches the truncation paths at the address, at a data byte, at a read after a repeated start, and at a read byte. The directed tests cover a launch with no phase bits, control and TX writes ignored while busy, an abort in mid-transfer, and the clearing of cause and error.

// File: rtl/i2c_txn_offload.sv
module i2c_txn_offload #(
  parameter bit TEN_BIT_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        eng_req,
  output logic [2:0]  eng_cmd,
  output logic [7:0]  eng_byte,
  input  logic        eng_done,
  input  logic        eng_nack,
  input  logic        eng_fault,
  input  logic [7:0]  eng_rx
);

  localparam logic [2:0] C_START   = 3'd0;
  localparam logic [2:0] C_RESTART = 3'd1;
  localparam logic [2:0] C_STOP    = 3'd2;
  localparam logic [2:0] C_WRITE   = 3'd3;
  localparam logic [2:0] C_RDACK   = 3'd4;
  localparam logic [2:0] C_RDNACK  = 3'd5;

  localparam logic [2:0] A_CTRL = 3'd0, A_TXL = 3'd1, A_TXH = 3'd2,
                         A_RXL = 3'd3, A_RXH = 3'd4, A_STAT = 3'd5, A_CAUSE = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_ADDR2, ST_WDATA, ST_RDATA, ST_STOP
  } st_t;

  st_t         st;
  logic [31:0] ctrl_q;
  logic [63:0] tx_q, rx_q;
  logic        do_rd, rs_q, ten_q, rd_ph, rs_now, cont_q, abort_q;
  logic [9:0]  addr_q;
  logic [2:0]  txlen, rxlen, idx;
  logic        err_q, cause_q;
  logic        ten_eff, busy, bad, launch;

  generate
    if (TEN_BIT_EN) begin : g_ten
      assign ten_eff = ten_q;
    end else begin : g_seven
      assign ten_eff = 1'b0;
    end
  endgenerate

  assign busy    = (st != ST_IDLE);
  assign eng_req = busy;
  assign irq     = cause_q;
  assign launch  = !busy && reg_wr && reg_addr == A_CTRL && reg_wdata[19]
                   && (reg_wdata[0] || reg_wdata[1]);
  assign bad     = eng_fault || (eng_nack && eng_cmd == C_WRITE);

  always_comb begin
    eng_cmd  = C_STOP;
    eng_byte = 8'h00;
    case (st)
      ST_START: eng_cmd = rs_now ? C_RESTART : C_START;
      ST_ADDR1: begin
        eng_cmd  = C_WRITE;
        eng_byte = ten_eff ? {5'b11110, addr_q[9:8], rd_ph} : {addr_q[6:0], rd_ph};
      end
      ST_ADDR2: begin
        eng_cmd  = C_WRITE;
        eng_byte = addr_q[7:0];
      end
      ST_WDATA: begin
        eng_cmd  = C_WRITE;
        eng_byte = tx_q[{idx, 3'b000} +: 8];
      end
      ST_RDATA: eng_cmd = (idx == rxlen) ? C_RDNACK : C_RDACK;
      default:  eng_cmd = C_STOP;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {ctrl_q[31:20], busy, ctrl_q[18:0]};
      A_TXL:   reg_rdata = tx_q[31:0];
      A_TXH:   reg_rdata = tx_q[63:32];
      A_RXL:   reg_rdata = rx_q[31:0];
      A_RXH:   reg_rdata = rx_q[63:32];
      A_STAT:  reg_rdata = {31'd0, err_q};
      A_CAUSE: reg_rdata = {31'd0, cause_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ctrl_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      do_rd   <= 1'b0;
      rs_q    <= 1'b0;
      ten_q   <= 1'b0;
      rd_ph   <= 1'b0;
      rs_now  <= 1'b0;
      cont_q  <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= '0;
      txlen   <= '0;
      rxlen   <= '0;
      idx     <= '0;
      err_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CAUSE) cause_q <= 1'b0;
      if (!busy && reg_wr) begin
        if (reg_addr == A_TXL) tx_q[31:0]  <= reg_wdata;
        if (reg_addr == A_TXH) tx_q[63:32] <= reg_wdata;
        if (reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      end
      if (busy && reg_wr && reg_addr == A_CTRL && !reg_wdata[19]) begin
        abort_q <= 1'b1;
        err_q   <= 1'b1;
      end
      if (launch) begin
        do_rd   <= reg_wdata[1];
        rd_ph   <= !reg_wdata[0];
        addr_q  <= reg_wdata[11:2];
        ten_q   <= reg_wdata[12];
        txlen   <= reg_wdata[15:13];
        rxlen   <= reg_wdata[18:16];
        rs_q    <= reg_wdata[20];
        rs_now  <= 1'b0;
        cont_q  <= 1'b0;
        abort_q <= 1'b0;
        err_q   <= 1'b0;
        cause_q <= 1'b0;
        rx_q    <= '0;
        idx     <= '0;
        st      <= ST_START;
      end else if (busy && eng_done) begin
        if (st == ST_STOP) begin
          if (cont_q && !abort_q && !err_q) begin
            st     <= ST_START;
            rd_ph  <= 1'b1;
            rs_now <= 1'b0;
            cont_q <= 1'b0;
          end else begin
            st      <= ST_IDLE;
            cause_q <= 1'b1;
          end
        end else if (bad || abort_q) begin
          err_q  <= 1'b1;
          cont_q <= 1'b0;
          st     <= ST_STOP;
        end else begin
          case (st)
            ST_START: st <= ST_ADDR1;
            ST_ADDR1: begin
              idx <= '0;
              st  <= ten_eff ? ST_ADDR2 : (rd_ph ? ST_RDATA : ST_WDATA);
            end
            ST_ADDR2: begin
              idx <= '0;
              st  <= rd_ph ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
              if (idx == txlen) begin
                if (do_rd && rs_q) begin
                  st     <= ST_START;
                  rd_ph  <= 1'b1;
                  rs_now <= 1'b1;
                end else begin
                  cont_q <= do_rd;
                  st     <= ST_STOP;
                end
              end else begin
                idx <= idx + 3'd1;
              end
            end
            ST_RDATA: begin
              rx_q[{idx, 3'b000} +: 8] <= eng_rx;
              if (idx == rxlen) st <= ST_STOP;
              else idx <= idx + 3'd1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R13: command held until the engine completes it
  p_hold_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_cmd) && $stable(eng_byte));

  // R4: cause only rises when a STOP command completes
  p_cause_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q) |-> $past(eng_done && eng_cmd == C_STOP));

  // R9: slave NACK on a written byte is followed by STOP
  p_stop_after_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_nack && eng_cmd == C_WRITE |=> eng_req && eng_cmd == C_STOP);

  // R10: fault on a non-STOP command is followed by STOP
  p_stop_after_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_fault && eng_cmd != C_STOP |=> eng_req && eng_cmd == C_STOP);

  // R5: the NACKed read is the last byte before STOP
  p_last_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_cmd == C_RDNACK |=> eng_req && eng_cmd == C_STOP);

  // R12: interrupt line tracks the cause flag
  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_CAUSE && !(busy && eng_done && st == ST_STOP) |=> !irq);

endmodule

// File: tb/test_i2c_txn_offload.sv
module test_i2c_txn_offload;

  localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_STOP = 3'd2,
                         C_WRITE = 3'd3, C_RDACK = 3'd4, C_RDNACK = 3'd5;

  function automatic logic [31:0] mk(input logic w, input logic r, input logic [9:0] a,
                                     input logic ten, input int tl, input int rl, input logic rs);
    logic [2:0] t3, r3;
    t3 = 3'(tl - 1);
    r3 = 3'(rl - 1);
    return {11'd0, rs, 1'b1, r3, t3, ten, a, r, w};
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic [63:0] tx;
    int          nk;
    int          ft;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{mk(1,0,10'h050,0,1,1,0), 64'h00000000_000000A5, -1, -1, 1'b0},  // R4
    '{mk(1,0,10'h021,0,8,1,0), 64'h88776655_44332211, -1, -1, 1'b0},  // R4 R3
    '{mk(0,1,10'h03B,0,1,1,0), 64'h0,                 -1, -1, 1'b0},  // R5
    '{mk(0,1,10'h011,0,1,8,0), 64'h0,                 -1, -1, 1'b0},  // R5 R3
    '{mk(1,1,10'h048,0,2,3,1), 64'h00000000_0000C3B2, -1, -1, 1'b0},  // R6
    '{mk(1,1,10'h00C,0,1,2,0), 64'h00000000_0000007E, -1, -1, 1'b0},  // R7
    '{mk(1,0,10'h2C7,1,3,1,0), 64'h00000000_00916D2A, -1, -1, 1'b0},  // R8
    '{mk(1,1,10'h155,1,1,2,1), 64'h00000000_000000E4, -1, -1, 1'b0},  // R8 R6
    '{mk(1,0,10'h06A,0,4,1,0), 64'h00000000_44332211,  1, -1, 1'b1},  // R9 address NACK
    '{mk(1,0,10'h06A,0,4,1,0), 64'h00000000_44332211,  3, -1, 1'b1},  // R9 data NACK
    '{mk(0,1,10'h027,0,1,4,0), 64'h0,                 -1,  3, 1'b1},  // R10 read fault
    '{mk(1,1,10'h019,0,2,2,1), 64'h00000000_00005566,  5, -1, 1'b1}   // R9 NACK after restart
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, eng_req, eng_done, eng_nack, eng_fault;
  logic [2:0] eng_cmd;
  logic [7:0] eng_byte, eng_rx;

  always #2 clk = ~clk;

  i2c_txn_offload i_i2c_txn_offload (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_fault(eng_fault), .eng_rx(eng_rx)
  );

  // behavioural byte engine with command log
  logic       m_clr = 1'b0;
  int         nack_at = -1, fault_at = -1;
  logic       m_busy;
  int         m_cnt, m_idx, m_rd, log_n;
  logic [7:0] m_rxv;
  logic [2:0] log_c [0:39];
  logic [7:0] log_b [0:39];

  always @(posedge clk) begin
    if (!rst_n || m_clr) begin
      m_busy <= 1'b0; m_cnt <= 0; m_idx <= 0; m_rd <= 0; log_n <= 0;
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_fault <= 1'b0; eng_rx <= 8'h00; m_rxv <= 8'h00;
    end else begin
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_fault <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          eng_done  <= 1'b1;
          eng_nack  <= (m_idx == nack_at);
          eng_fault <= (m_idx == fault_at);
          eng_rx    <= m_rxv;
          m_busy    <= 1'b0;
        end else m_cnt <= m_cnt - 1;
      end else if (eng_req && !eng_done) begin
        if (log_n < 40) begin
          log_c[log_n] <= eng_cmd;
          log_b[log_n] <= eng_byte;
        end
        m_idx  <= log_n;
        log_n  <= log_n + 1;
        m_busy <= 1'b1;
        m_cnt  <= 1;
        if (eng_cmd == C_RDACK || eng_cmd == C_RDNACK) begin
          m_rxv <= 8'h5A + 8'(17 * m_rd);
          m_rd  <= m_rd + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0, cycles = 0;
  logic [2:0]  exp_c [0:39];
  logic [7:0]  exp_b [0:39];
  int          exp_n;
  logic [63:0] exp_rx;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push(input logic [2:0] c, input logic [7:0] b);
    exp_c[exp_n] = c; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic push_addr(input logic ten, input logic [9:0] a, input logic dir);
    if (ten) begin
      push(C_WRITE, {5'b11110, a[9:8], dir});
      push(C_WRITE, a[7:0]);
    end else push(C_WRITE, {a[6:0], dir});
  endtask

  task automatic build_exp(input logic [31:0] c, input logic [63:0] tx, input int nk, input int ft);
    int tl, rl, k, j;
    tl = int'(c[15:13]) + 1;
    rl = int'(c[18:16]) + 1;
    exp_n = 0;
    if (c[0]) begin
      push(C_START, 8'h00);
      push_addr(c[12], c[11:2], 1'b0);
      for (int i = 0; i < tl; i++) push(C_WRITE, tx[i*8 +: 8]);
    end
    if (c[0] && c[1]) begin
      if (c[20]) push(C_RESTART, 8'h00);
      else begin push(C_STOP, 8'h00); push(C_START, 8'h00); end
    end
    if (c[1]) begin
      if (!c[0]) push(C_START, 8'h00);
      push_addr(c[12], c[11:2], 1'b1);
      for (int i = 0; i < rl; i++) push((i == rl - 1) ? C_RDNACK : C_RDACK, 8'h00);
    end
    push(C_STOP, 8'h00);
    k = (nk >= 0) ? nk : ft;
    if (k >= 0 && k < exp_n) begin
      exp_n = k + 1;
      push(C_STOP, 8'h00);
    end
    exp_rx = '0;
    j = 0;
    for (int i = 0; i < exp_n; i++)
      if ((exp_c[i] == C_RDACK || exp_c[i] == C_RDNACK) && i != ft) begin
        exp_rx[j*8 +: 8] = 8'h5A + 8'(17 * j);
        j++;
      end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_log(input int nk, input int ft);
    @(negedge clk);
    nack_at = nk; fault_at = ft; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check(irq === 1'b1, req, 64'(n), 64'd3000);
  endtask

  task automatic cmp_seq(input string req, input int v);
    logic ok;
    int bad_i;
    ok = (log_n == exp_n);
    bad_i = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad_i < 0 && (log_c[i] !== exp_c[i] || (exp_c[i] == C_WRITE && log_b[i] !== exp_b[i])))
        bad_i = i;
    if (bad_i >= 0) begin
      ok = 1'b0;
      $display("  vector %0d mismatch at command %0d: %0d/%h vs %0d/%h", v, bad_i,
               log_c[bad_i], log_b[bad_i], exp_c[bad_i], exp_b[bad_i]);
    end
    check(ok, req, 64'(log_n), 64'(exp_n));
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] cw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R12 R13 reset state
    reg_read(3'd0, d); check(d == 0, "R2 ctrl reset", 64'(d), 0);
    reg_read(3'd5, d); check(d == 0, "R2 status reset", 64'(d), 0);
    reg_read(3'd6, d); check(d == 0, "R12 cause reset", 64'(d), 0);
    check(irq == 1'b0 && eng_req == 1'b0, "R13 idle outputs", 64'({irq, eng_req}), 0);

    // R1 launch without phase bits does nothing
    clear_log(-1, -1);
    reg_write(3'd0, 32'h0008_0000);
    repeat (20) @(negedge clk);
    check(log_n == 0 && irq == 1'b0, "R1 no-phase launch", 64'(log_n), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      clear_log(VECS[v].nk, VECS[v].ft);
      build_exp(VECS[v].ctrl, VECS[v].tx, VECS[v].nk, VECS[v].ft);
      reg_write(3'd1, VECS[v].tx[31:0]);
      reg_write(3'd2, VECS[v].tx[63:32]);
      reg_write(3'd0, VECS[v].ctrl);
      wait_irq("R4 completion");
      repeat (2) @(negedge clk);
      cmp_seq("R13 command sequence (R4-R10 by vector)", v);
      reg_read(3'd5, d); check(d[0] == VECS[v].err, "R9 R10 error flag", 64'(d), 64'(VECS[v].err));
      reg_read(3'd6, d); check(d[0] == 1'b1, "R2 cause set", 64'(d), 1);
      reg_read(3'd3, d); check(d == exp_rx[31:0], "R5 RX low", 64'(d), 64'(exp_rx[31:0]));
      reg_read(3'd4, d); check(d == exp_rx[63:32], "R3 RX high", 64'(d), 64'(exp_rx[63:32]));
    end

    // R12 cause write clears irq
    reg_write(3'd6, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R12 cause clear", 64'(irq), 0);

    // R11 writes while busy are ignored; R1 busy readback; R12 launch clears error
    clear_log(-1, -1);
    cw = mk(1, 0, 10'h05D, 0, 2, 1, 0);
    build_exp(cw, 64'h0000_0000_0000_9A3C, -1, -1);
    reg_write(3'd1, 32'h0000_9A3C);
    reg_write(3'd0, cw);
    reg_read(3'd5, d); check(d[0] == 1'b0, "R12 launch clears error", 64'(d), 0);
    reg_read(3'd0, d); check(d[19] == 1'b1, "R1 busy readback", 64'(d[19]), 1);
    reg_write(3'd0, mk(0, 1, 10'h011, 0, 1, 5, 1));
    reg_write(3'd1, 32'hFFFF_FFFF);
    wait_irq("R11 completion");
    repeat (2) @(negedge clk);
    cmp_seq("R11 busy writes ignored", 100);
    reg_read(3'd5, d); check(d[0] == 1'b0, "R11 no error", 64'(d), 0);
    reg_read(3'd0, d); check(d[19] == 1'b0, "R1 idle readback", 64'(d[19]), 0);

    // R11 abort by clearing enable
    clear_log(-1, -1);
    reg_write(3'd0, mk(1, 0, 10'h033, 0, 8, 1, 0));
    while (log_n < 3) @(negedge clk);
    reg_write(3'd0, 32'h0);
    wait_irq("R11 abort completion");
    repeat (2) @(negedge clk);
    check(log_n >= 4 && log_n <= 6, "R11 abort length", 64'(log_n), 5);
    check(log_c[log_n - 1] == C_STOP, "R11 abort ends with STOP", 64'(log_c[log_n - 1]), 64'(C_STOP));
    reg_read(3'd5, d); check(d[0] == 1'b1, "R11 abort error", 64'(d), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule